// File: doc/BRIEF.md
# Serial Command Port for a Low-Frequency Tag Reader Front End

This block is the host-facing control port of a reader front end. A host drives a serial clock and a data line; the block returns data on a separate line that idles high, as an open-drain output with a pull-up would. Both incoming lines are sampled on the system clock. A transaction opens with a start condition: the data line rises while the serial clock is high. After that, command bits are captured most significant bit first, on each rising edge of the serial clock.

Commands have two lengths. Two short commands are decided after their third bit and switch the front end into a tag-listening mode or a tag-writing mode. The longer commands are eight bits. They load the demodulator sampling time, load one of four 4-bit configuration pages, load the write-pulse width and enter writing mode, or ask for an eight-bit reply. A reply can carry the sampling time, the measured carrier phase, or one configuration page. The upper nibble of a page reply depends on the page: for the two lower pages it is the pulse width, and for the two upper pages it is live status. The reply goes out MSB first on the eight serial clock pulses that follow the command.

Top module: `ser_cmd_if`

## Requirements
- R1: A rise of `sdi` while `sck` is high starts command reception. Serial clock pulses outside a transaction change no register and enter no mode.
- R2: The 3-bit code 111 enters listening mode after its third bit. While in that mode `sdo` follows `tag_bit_i`.
- R3: The 3-bit code 110 enters writing mode after its third bit. It keeps the stored pulse width, which is 0 after reset.
- R4: Listening and writing mode are never active together. Either mode ends on the next rising edge of `sck`, and `sdo` then returns high.
- R5: The byte 10 followed by six bits loads those six bits into `samp_time_o`.
- R6: The byte 01, then a 2-bit page number, then four data bits loads the page. Page p appears at `cfg_o[4p+3:4p]`.
- R7: The byte 000001 followed by a page number replies with the page data in bits 3..0. For pages 0 and 1, bits 7..4 hold the pulse width. For pages 2 and 3, bits 7..4 hold 0, 0, `amp_cmp_i`, `ant_fail_i`, sampled at the rising edge of the eighth command bit.
- R8: The byte 00000010 replies with {00, sampling time}. The byte 00001000 replies with {00, `phase_i`}. A reply is shifted MSB first, one bit valid on `sdo` during the high phase of each of the next eight `sck` pulses.
- R9: The byte 0001 followed by four bits stores those bits as the pulse width on `pulse_n_o` and enters writing mode.
- R10: After reset, `cfg_o` is 16'h0008 (only page 0 bit 3 set), `samp_time_o` and `pulse_n_o` are 0, both modes are off and `sdo` is high.
- R11: A new start condition abandons a partly received command without changing any register.
- R12: An 8-bit code outside the set above changes nothing, and `sdo` stays high on the pulses that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial data in |
| sdo | output | 1 | Serial data out, idles high |
| tag_bit_i | input | 1 | Digitized demodulated tag data |
| phase_i | input | 6 | Measured carrier phase |
| amp_cmp_i | input | 1 | Amplitude comparison status |
| ant_fail_i | input | 1 | Antenna failure status |
| listen_o | output | 1 | Listening (read tag) mode active |
| write_o | output | 1 | Writing (write tag) mode active |
| pulse_n_o | output | 4 | Stored write-pulse width |
| samp_time_o | output | 6 | Demodulator sampling time |
| cfg_o | output | 16 | Four 4-bit configuration pages, page 0 lowest |

## Verification
The rising edge of the eighth bit of a page read can coincide with a change in the live status inputs. At that same edge the block captures the bit, decodes the command and freezes the reply. The bench raises `amp_cmp_i` in the same system clock cycle as that eighth `sck` rise, then raises `ant_fail_i` one cycle later. The reply must contain the first change and not the second. A second overlap is tested as well: a start condition arrives partway through a command, and the command that follows must decode cleanly.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;

    localparam int CMD_W   = 8;
    localparam int SHORT_W = 3;
    localparam int TS_W    = 6;
    localparam int PG_W    = 4;
    localparam int N_PG    = 4;
    localparam int PSEL_W  = $clog2(N_PG);
    localparam int N_W     = 4;
    localparam int CNT_W   = $clog2(CMD_W);
    localparam int CFG_W   = PG_W * N_PG;
    localparam logic [CFG_W-1:0] CFG_RST = 16'h0008;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_RESP, ST_LISTEN, ST_WRITE
    } port_st_t;

    typedef enum logic [2:0] {
        K_NONE, K_SET_TS, K_GET_TS, K_SET_PG, K_GET_PG, K_PHASE, K_SET_N
    } cmd_kind_t;

    typedef struct packed {
        cmd_kind_t          kind;
        logic [PSEL_W-1:0]  page;
        logic [TS_W-1:0]    arg;
    } cmd_t;

    function automatic cmd_t decode_byte(input logic [CMD_W-1:0] b);
        cmd_t c;
        c.kind = K_NONE;
        c.page = '0;
        c.arg  = b[TS_W-1:0];
        if (b[7:6] == 2'b10) begin
            c.kind = K_SET_TS;
        end else if (b[7:6] == 2'b01) begin
            c.kind = K_SET_PG;
            c.page = b[5:4];
            c.arg  = {2'b00, b[3:0]};
        end else if (b[7:4] == 4'b0001) begin
            c.kind = K_SET_N;
            c.arg  = {2'b00, b[3:0]};
        end else if (b == 8'h02) begin
            c.kind = K_GET_TS;
        end else if (b[7:2] == 6'b000001) begin
            c.kind = K_GET_PG;
            c.page = b[1:0];
        end else if (b == 8'h08) begin
            c.kind = K_PHASE;
        end
        return c;
    endfunction

endpackage

// File: rtl/ser_cmd_edge.sv
module ser_cmd_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic sdi,
    output logic start,
    output logic rise
);
    logic sck_q, sdi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sdi_q <= 1'b0;
        end else begin
            sck_q <= sck;
            sdi_q <= sdi;
        end
    end

    assign start = sck & sck_q & sdi & ~sdi_q;
    assign rise  = sck & ~sck_q;
endmodule

// File: rtl/ser_cmd_regs.sv
module ser_cmd_regs
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ts,
    input  logic              wr_pg,
    input  logic              wr_n,
    input  cmd_t              cmd,
    output logic [TS_W-1:0]   ts,
    output logic [N_W-1:0]    n_val,
    output logic [CFG_W-1:0]  cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ts    <= '0;
            n_val <= '0;
        end else begin
            if (wr_ts) ts    <= cmd.arg;
            if (wr_n)  n_val <= cmd.arg[N_W-1:0];
        end
    end

    for (genvar g = 0; g < N_PG; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (rst)
                cfg[g*PG_W +: PG_W] <= CFG_RST[g*PG_W +: PG_W];
            else if (wr_pg && cmd.page == PSEL_W'(g))
                cfg[g*PG_W +: PG_W] <= cmd.arg[PG_W-1:0];
        end
    end
endmodule

// File: rtl/ser_cmd_ctrl.sv
module ser_cmd_ctrl
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rise,
    input  logic              bit_in,
    input  logic [TS_W-1:0]   ts,
    input  logic [N_W-1:0]    n_val,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [TS_W-1:0]   phase,
    input  logic              amp,
    input  logic              ant,
    output port_st_t          st,
    output cmd_t              cmd,
    output logic              wr_ts,
    output logic              wr_pg,
    output logic              wr_n,
    output logic              dout_q
);
    logic [CMD_W-1:0] sr, nxt, resp;
    logic [CNT_W-1:0] cnt;
    logic [PG_W-1:0]  pg_nib;
    logic             last;

    assign nxt  = {sr[CMD_W-2:0], bit_in};
    assign cmd  = decode_byte(nxt);
    assign last = (st == ST_CMD) && rise && !start && (cnt == CNT_W'(CMD_W-1));
    assign wr_ts = last && (cmd.kind == K_SET_TS);
    assign wr_pg = last && (cmd.kind == K_SET_PG);
    assign wr_n  = last && (cmd.kind == K_SET_N);

    always_comb begin
        pg_nib = cfg[int'(cmd.page)*PG_W +: PG_W];
        case (cmd.kind)
            K_GET_TS: resp = {2'b00, ts};
            K_PHASE:  resp = {2'b00, phase};
            K_GET_PG: resp = cmd.page[PSEL_W-1] ? {2'b00, amp, ant, pg_nib}
                                                : {n_val, pg_nib};
            default:  resp = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sr     <= '0;
            dout_q <= 1'b1;
        end else if (start) begin
            st     <= ST_CMD;
            cnt    <= '0;
            sr     <= '0;
            dout_q <= 1'b1;
        end else if (rise) begin
            case (st)
                ST_CMD: begin
                    dout_q <= 1'b1;
                    sr     <= nxt;
                    cnt    <= cnt + 1'b1;
                    if (cnt == CNT_W'(SHORT_W-1) && nxt[2:0] == 3'b111) begin
                        st <= ST_LISTEN;
                    end else if (cnt == CNT_W'(SHORT_W-1) && nxt[2:0] == 3'b110) begin
                        st <= ST_WRITE;
                    end else if (cnt == CNT_W'(CMD_W-1)) begin
                        cnt <= '0;
                        case (cmd.kind)
                            K_GET_TS, K_GET_PG, K_PHASE: begin
                                st <= ST_RESP;
                                sr <= resp;
                            end
                            K_SET_N: st <= ST_WRITE;
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
                ST_RESP: begin
                    dout_q <= sr[CMD_W-1];
                    sr     <= {sr[CMD_W-2:0], 1'b0};
                    cnt    <= cnt + 1'b1;
                    if (cnt == CNT_W'(CMD_W-1)) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end
                end
                default: begin
                    st     <= ST_IDLE;
                    dout_q <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ser_cmd_if.sv
module ser_cmd_if
    import ser_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    input  logic              tag_bit_i,
    input  logic [TS_W-1:0]   phase_i,
    input  logic              amp_cmp_i,
    input  logic              ant_fail_i,
    output logic              listen_o,
    output logic              write_o,
    output logic [N_W-1:0]    pulse_n_o,
    output logic [TS_W-1:0]   samp_time_o,
    output logic [CFG_W-1:0]  cfg_o
);
    logic      start, rise, wr_ts, wr_pg, wr_n, dout_q;
    port_st_t  st;
    cmd_t      cmd;

    ser_cmd_edge u_edge (
        .clk(clk), .rst(rst), .sck(sck), .sdi(sdi),
        .start(start), .rise(rise)
    );

    ser_cmd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .rise(rise), .bit_in(sdi),
        .ts(samp_time_o), .n_val(pulse_n_o), .cfg(cfg_o),
        .phase(phase_i), .amp(amp_cmp_i), .ant(ant_fail_i),
        .st(st), .cmd(cmd), .wr_ts(wr_ts), .wr_pg(wr_pg), .wr_n(wr_n),
        .dout_q(dout_q)
    );

    ser_cmd_regs u_regs (
        .clk(clk), .rst(rst), .wr_ts(wr_ts), .wr_pg(wr_pg), .wr_n(wr_n),
        .cmd(cmd), .ts(samp_time_o), .n_val(pulse_n_o), .cfg(cfg_o)
    );

    assign listen_o = (st == ST_LISTEN);
    assign write_o  = (st == ST_WRITE);
    assign sdo      = listen_o ? tag_bit_i : dout_q;
endmodule

// File: rtl/ser_cmd_chk.sv
module ser_cmd_chk
    import ser_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sck,
    input logic              sdo,
    input logic              listen_o,
    input logic              write_o,
    input logic [N_W-1:0]    pulse_n_o,
    input logic [TS_W-1:0]   samp_time_o,
    input logic [CFG_W-1:0]  cfg_o,
    input logic              wr_ts,
    input logic              wr_pg,
    input logic              wr_n
);
    a_r10_reset_vals: assert property (@(posedge clk)
        rst |=> (cfg_o == CFG_RST && samp_time_o == '0 && pulse_n_o == '0
                 && !listen_o && !write_o && sdo));

    a_r4_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(listen_o && write_o));

    a_r4_mode_exit: assert property (@(posedge clk) disable iff (rst)
        ((listen_o || write_o) && sck && !$past(sck)) |=> (!listen_o && !write_o));

    a_r2_mode_entry_on_edge: assert property (@(posedge clk) disable iff (rst)
        ($rose(listen_o) || $rose(write_o)) |-> ($past(sck) && !$past(sck, 2)));

    a_r5_ts_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(samp_time_o) |-> $past(wr_ts));

    a_r6_cfg_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_o) |-> $past(wr_pg));

    a_r9_n_on_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(pulse_n_o) |-> $past(wr_n));
endmodule

bind ser_cmd_if ser_cmd_chk u_chk (.*);

// File: tb/sim_ser_cmd_if.sv
module sim_ser_cmd_if;
    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic tag_bit_i = 1'b0, amp_cmp_i = 1'b0, ant_fail_i = 1'b0;
    logic [5:0]  phase_i = 6'h00;
    logic        sdo, listen_o, write_o;
    logic [3:0]  pulse_n_o;
    logic [5:0]  samp_time_o;
    logic [15:0] cfg_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    logic       mon_on = 1'b0;
    string      mon_req = "";

    always #2.5 clk = ~clk;

    ser_cmd_if u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        @(negedge clk) sdi = b;
        wait_clk(4); sck = 1'b1;
        wait_clk(4); sck = 1'b0;
    endtask

    task automatic start_c();
        @(negedge clk) sdi = 1'b0;
        wait_clk(2); sck = 1'b1;
        wait_clk(4); sdi = 1'b1;
        wait_clk(4); sck = 1'b0;
        wait_clk(2);
    endtask

    task automatic send(input logic [7:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
        wait_clk(2);
    endtask

    // driver side of the scoreboard: queue the expected reply, clock it out
    task automatic reply(input string req, input logic [7:0] exp);
        exp_q.push_back(exp);
        mon_req = req;
        mon_on  = 1'b1;
        for (int i = 0; i < 8; i++) sbit(1'b0);
        wait (!mon_on);
        wait_clk(2);
    endtask

    // monitor: samples sdo mid high phase of each sck pulse
    logic [7:0] mon_sr = 8'h00;
    int         mon_n = 0;
    always @(posedge sck) begin
        if (mon_on) begin
            #10;
            mon_sr = {mon_sr[6:0], sdo};
            mon_n++;
            if (mon_n == 8) begin
                chk(mon_req, {24'h0, mon_sr}, {24'h0, exp_q.pop_front()});
                mon_n  = 0;
                mon_on = 1'b0;
            end
        end
    end

    initial begin
        wait_clk(200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R10 reset state
        chk("R10 cfg", cfg_o, 16'h0008);
        chk("R10 samp", samp_time_o, 0);
        chk("R10 pulse", pulse_n_o, 0);
        chk("R10 modes", {listen_o, write_o}, 0);
        chk("R10 sdo", sdo, 1);

        // R1 bits without a start change nothing
        send(8'b10_111111, 8);
        chk("R1 no start", samp_time_o, 0);

        // R3 write mode with default width 0
        start_c(); send(8'b110, 3);
        chk("R3 write mode", write_o, 1);
        chk("R3 default width", pulse_n_o, 0);
        sbit(1'b0); wait_clk(2);
        chk("R4 write exit", write_o, 0);

        // R5 / R8 sampling time
        start_c(); send(8'b10_101101, 8);
        chk("R5 samp set", samp_time_o, 6'h2D);
        start_c(); send(8'h02, 8);
        reply("R8 samp reply", 8'h2D);

        // R6 pages
        start_c(); send(8'b01_10_1010, 8);
        chk("R6 page2", cfg_o, 16'h0A08);
        start_c(); send(8'b01_00_0101, 8);
        chk("R6 page0", cfg_o, 16'h0A05);

        // R9 width plus write mode
        start_c(); send(8'b0001_0110, 8);
        chk("R9 width", pulse_n_o, 4'h6);
        chk("R9 write mode", write_o, 1);
        sbit(1'b0); wait_clk(2);
        chk("R4 exit after width", write_o, 0);

        // R7 page 0 carries width
        start_c(); send(8'b000001_00, 8);
        reply("R7 page0 reply", 8'h65);

        // R7 status snapshot at the eighth rising edge
        start_c(); send(8'b0000011, 7);
        @(negedge clk) sdi = 1'b0;
        wait_clk(4); sck = 1'b1; amp_cmp_i = 1'b1;
        wait_clk(1); ant_fail_i = 1'b1;
        wait_clk(3); sck = 1'b0;
        wait_clk(2);
        reply("R7 page2 status snapshot", 8'h2A);
        ant_fail_i = 1'b0; amp_cmp_i = 1'b0;

        // R8 phase
        phase_i = 6'h17;
        start_c(); send(8'h08, 8);
        reply("R8 phase reply", 8'h17);

        // R2 listening mode
        start_c(); send(8'b111, 3);
        chk("R2 listen mode", listen_o, 1);
        tag_bit_i = 1'b0; wait_clk(1);
        chk("R2 sdo low", sdo, 0);
        tag_bit_i = 1'b1; wait_clk(1);
        chk("R2 sdo high", sdo, 1);
        tag_bit_i = 1'b0; wait_clk(1);
        sbit(1'b0); wait_clk(2);
        chk("R4 listen exit", listen_o, 0);
        chk("R4 sdo idle", sdo, 1);

        // R3 short write keeps stored width
        start_c(); send(8'b110, 3);
        chk("R3 keeps width", pulse_n_o, 4'h6);
        chk("R4 exclusive", {listen_o, write_o}, 2'b01);
        sbit(1'b0); wait_clk(2);

        // R11 abort partial command
        start_c(); send(8'b10_11, 4);
        start_c(); send(8'b01_11_0011, 8);
        chk("R11 samp kept", samp_time_o, 6'h2D);
        chk("R11 R1 next cmd", cfg_o, 16'h3A05);

        // R12 undefined code
        start_c(); send(8'h00, 8);
        reply("R12 no reply", 8'hFF);
        chk("R12 cfg kept", cfg_o, 16'h3A05);
        chk("R12 samp kept", samp_time_o, 6'h2D);
        chk("R12 width kept", pulse_n_o, 4'h6);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule